// File: doc/BRIEF.md
# Trigger-Synchronized Timer Pair

Two identical up-counting timers sit side by side, each with a small register set written through a shared synchronous write port. One timer, the master, arms on a rising edge of an external pin. It can put its own run state onto a trigger output. The other timer, the slave, arms on a rising edge of the master's trigger output. Once both are armed the two counters advance together with no software involved. Each counter counts up to its reload value, wraps to zero, and keeps running until software clears its run bit.

The pin is brought into the clock domain through a flip-flop synchronizer before its edge is detected. The slave sees the master's trigger output one register later than the master sees its own trigger. To cover this, the master can hold back its own counting and its trigger flag by one clock. Both counters then take their first step on the same edge, and both flags rise in the same cycle. Software can preset either counter before arming, giving a fixed offset between the two counts, or zero them both with the update bit.

Top module: `tmr_pair`

## Requirements
- R1: After reset both counters read 0, both trigger flags read 0 and both trigger outputs read 0.
- R2: A timer's trigger output equals its run bit when its master-mode field (control bits 3:1) is 001, and is 0 for any other value of that field.
- R3: With trigger-select (control bits 11:7) 00100, slave-mode (control bits 6:4) 110 and the delay bit (control bit 12) set, a rising edge on the external input sets the run bit two clocks after the input is first sampled high. It also sets the trigger flag one clock later, so the flag is visible on the fourth clock edge after the input rises.
- R4: With trigger-select 00000 and slave-mode 110, a rising edge on the other timer's trigger output sets the slave's run bit and its trigger flag on the next clock edge.
- R5: With the master's delay bit set and both counters zeroed, both flags rise in the same cycle and the two counters show equal values on every cycle afterwards.
- R6: A value written to a counter register (address 1) before arming is kept as a constant offset between the two counts while both run.
- R7: A running counter steps by one per clock and goes to 0 on the step after it equals its reload value (address 2, all ones after reset).
- R8: Writing the status register (address 4) with bit 0 at 0 clears the trigger flag, and writing it with bit 0 at 1 leaves the flag unchanged.
- R9: A trigger edge has no effect when the slave-mode field is not 110: the run bit, the flag and the counter stay as they were.
- R10: A trigger edge does not reset the counter: counting resumes from the value the counter held.
- R11: With the master's delay bit clear, the master takes its first step one clock before the slave, so the master count stays exactly one ahead.
- R12: Writing the update register (address 3) with bit 0 at 1 sets the counter to 0. Writing the control register (address 0) loads all control fields, with the run bit at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | 1 | Asynchronous external trigger pin |
| wr_en | input | 1 | Register write strobe |
| wr_unit | input | 1 | Target timer: 0 master, 1 slave |
| wr_addr | input | 3 | Register address: 0 control, 1 counter, 2 reload, 3 update, 4 status |
| wr_data | input | DATA_W | Write data |
| mst_cnt | output | CNT_W | Master counter value |
| slv_cnt | output | CNT_W | Slave counter value |
| mst_flag | output | 1 | Master trigger flag |
| slv_flag | output | 1 | Slave trigger flag |
| mst_trgo | output | 1 | Master trigger output |
| slv_trgo | output | 1 | Slave trigger output |

## Verification
The checker watches several rules on every cycle. A counter changes only by a single step or a wrap to zero unless a write intervened. A flag falls only after a clearing status write. The slave's run bit rises only from a write or in trigger mode. A rise of the master's trigger output starts an armed slave on the next edge. Lockstep counting, the kept offset, the one-clock lead without the delay bit, the synchronizer latency and the ignored trigger outside trigger mode depend on the full arming sequence. Only the bench's scenarios show these, with a behavioural model compared against the outputs on every clock.

// File: rtl/tmr_pair_pkg.sv
// Shared encodings and types for the trigger-synchronized timer pair.
// Assumes the control register layout below is fixed by software.
package tmr_pair_pkg;

    localparam int ADDR_W = 3;
    localparam int CTRL_W = 13;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_CNT  = 3'd1,
        REG_ARR  = 3'd2,
        REG_EVT  = 3'd3,
        REG_STAT = 3'd4
    } reg_addr_e;

    localparam logic [2:0] MMS_ENABLE  = 3'b001;
    localparam logic [2:0] SMS_TRIGGER = 3'b110;
    localparam logic [4:0] TS_ITR0     = 5'b00000;
    localparam logic [4:0] TS_EXT1     = 5'b00100;

    // Control register: bit 12 delay, 11:7 trigger select, 6:4 slave mode,
    // 3:1 master mode, 0 run.
    typedef struct packed {
        logic       msm;
        logic [4:0] ts;
        logic [2:0] sms;
        logic [2:0] mms;
        logic       cen;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_sync_edge.sv
// Brings an asynchronous pin into the clock domain through STAGES flops and
// flags a rising edge of the synchronized level for one cycle.
// Assumes STAGES >= 2.
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES:0] chain;

    // Shift the pin through the synchronizer and one extra history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], din};
    end

    // Rising edge on the last synchronizer stage.
    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/tmr_counter.sv
// Up-counter with load, clear and wrap at a reload value.
// Assumes load has priority over clear, and clear over stepping.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] arr,
    output logic [CNT_W-1:0] cnt
);

    // Count register update with software overrides.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load_en) cnt <= load_val;
        else if (clear)   cnt <= '0;
        else if (step)    cnt <= (cnt == arr) ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/tmr_unit.sv
// One timer: control, reload and status registers, trigger selection,
// trigger-mode arming and the optional one-clock start delay.
// Assumes DATA_W covers both CNT_W and the control register width.
module tmr_unit
    import tmr_pair_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rise,
    input  logic              itr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt,
    output logic              flag,
    output logic              trgo,
    output tmr_ctrl_t         ctrl
);

    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] arr_q;
    logic             cen_d, evt_d, itr_q;
    logic             src_rise, trig_evt, flag_evt, count_step;
    logic             wr_ctrl, wr_cnt, wr_arr, wr_evt, wr_stat;

    assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
    assign wr_cnt  = wr_en && (wr_addr == REG_CNT);
    assign wr_arr  = wr_en && (wr_addr == REG_ARR);
    assign wr_evt  = wr_en && (wr_addr == REG_EVT);
    assign wr_stat = wr_en && (wr_addr == REG_STAT);

    // Pick the trigger source edge named by the trigger-select field.
    always_comb begin
        if (ctrl_q.ts == TS_EXT1)      src_rise = ext_rise;
        else if (ctrl_q.ts == TS_ITR0) src_rise = itr & ~itr_q;
        else                           src_rise = 1'b0;
    end

    assign trig_evt   = (ctrl_q.sms == SMS_TRIGGER) && src_rise;
    assign flag_evt   = ctrl_q.msm ? evt_d : trig_evt;
    assign count_step = ctrl_q.msm ? cen_d : ctrl_q.cen;

    // Control register; a trigger in trigger mode sets the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl)  ctrl_q     <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
            if (trig_evt) ctrl_q.cen <= 1'b1;
        end
    end

    // Reload register, all ones out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      arr_q <= '1;
        else if (wr_arr) arr_q <= wr_data[CNT_W-1:0];
    end

    // Delay stages for the master/slave start and the internal trigger edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_d <= 1'b0;
            evt_d <= 1'b0;
            itr_q <= 1'b0;
        end else begin
            cen_d <= ctrl_q.cen;
            evt_d <= trig_evt;
            itr_q <= itr;
        end
    end

    // Trigger flag: set on trigger, cleared by writing 0 to bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag <= 1'b0;
        else if (flag_evt)               flag <= 1'b1;
        else if (wr_stat && !wr_data[0]) flag <= 1'b0;
    end

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (wr_cnt),
        .load_val (wr_data[CNT_W-1:0]),
        .clear    (wr_evt && wr_data[0]),
        .step     (count_step),
        .arr      (arr_q),
        .cnt      (cnt)
    );

    assign trgo = (ctrl_q.mms == MMS_ENABLE) && ctrl_q.cen;
    assign ctrl = ctrl_q;

endmodule

// File: rtl/tmr_pair.sv
// Master/slave timer pair: unit 0 is the master, unit 1 the slave. Each
// unit's internal trigger 0 is the other unit's trigger output.
// Assumes DATA_W >= CNT_W and DATA_W >= 13.
module tmr_pair
    import tmr_pair_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_in,
    input  logic              wr_en,
    input  logic              wr_unit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  mst_cnt,
    output logic [CNT_W-1:0]  slv_cnt,
    output logic              mst_flag,
    output logic              slv_flag,
    output logic              mst_trgo,
    output logic              slv_trgo
);

    localparam int NUM_UNITS = 2;

    logic             ext_rise;
    logic [CNT_W-1:0] unit_cnt  [NUM_UNITS];
    logic             unit_flag [NUM_UNITS];
    logic             unit_trgo [NUM_UNITS];
    tmr_ctrl_t        unit_ctrl [NUM_UNITS];

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_in),
        .rise  (ext_rise)
    );

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        tmr_unit #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .ext_rise (ext_rise),
            .itr      (unit_trgo[NUM_UNITS-1-g]),
            .wr_en    (wr_en && (wr_unit == 1'(g))),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .cnt      (unit_cnt[g]),
            .flag     (unit_flag[g]),
            .trgo     (unit_trgo[g]),
            .ctrl     (unit_ctrl[g])
        );
    end

    assign mst_cnt  = unit_cnt[0];
    assign slv_cnt  = unit_cnt[1];
    assign mst_flag = unit_flag[0];
    assign slv_flag = unit_flag[1];
    assign mst_trgo = unit_trgo[0];
    assign slv_trgo = unit_trgo[1];

endmodule

// File: rtl/tmr_pair_chk.sv
// Cycle rules for the timer pair, attached to every tmr_pair instance.
// Assumes the control structures of both units are visible to the binder.
module tmr_pair_chk
    import tmr_pair_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_unit,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [CNT_W-1:0]  mst_cnt,
    input logic              mst_flag,
    input logic              slv_flag,
    input logic              mst_trgo,
    input tmr_ctrl_t         slv_ctrl
);

    // R7: without a write, the master count only steps by one or wraps to 0.
    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && (mst_cnt != $past(mst_cnt)))
        |-> ((mst_cnt == $past(mst_cnt) + 1'b1) || (mst_cnt == '0)));

    // R8: the master flag falls only after a clearing status write.
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mst_flag)
        |-> $past(wr_en && !wr_unit && (wr_addr == REG_STAT) && !wr_data[0]));

    // R9: the slave's run bit rises only from a write or in trigger mode.
    p_cen_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slv_ctrl.cen)
        |-> ($past(wr_en && wr_unit) || $past(slv_ctrl.sms == SMS_TRIGGER)));

    // R4: an armed slave starts on the edge after the master trigger rises.
    p_slv_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mst_trgo) && (slv_ctrl.ts == TS_ITR0)
         && (slv_ctrl.sms == SMS_TRIGGER) && !slv_ctrl.msm && !(wr_en && wr_unit))
        |=> (slv_ctrl.cen && slv_flag));

endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_unit  (wr_unit),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mst_cnt  (mst_cnt),
    .mst_flag (mst_flag),
    .slv_flag (slv_flag),
    .mst_trgo (mst_trgo),
    .slv_ctrl (unit_ctrl[1])
);

// File: tb/tb_tmr_pair.sv
`timescale 1ns/1ps
// Bench for the timer pair: a behavioural model stepped on every clock plus
// directed scenarios with hand-derived expectations.
module tb_tmr_pair;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_in = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_unit = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [CNT_W-1:0]  mst_cnt, slv_cnt;
    logic              mst_flag, slv_flag, mst_trgo, slv_trgo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_pair #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .wr_en(wr_en),
        .wr_unit(wr_unit), .wr_addr(wr_addr), .wr_data(wr_data),
        .mst_cnt(mst_cnt), .slv_cnt(slv_cnt), .mst_flag(mst_flag),
        .slv_flag(slv_flag), .mst_trgo(mst_trgo), .slv_trgo(slv_trgo)
    );

    // ---------------- behavioural model ----------------
    int m_cen[2], m_cend[2], m_evtd[2], m_flag[2], m_cnt[2], m_arr[2];
    int m_mms[2], m_sms[2], m_ts[2], m_msm[2], m_itrq[2];
    int ext_hist[$];
    int old_trgo[2];
    int ext_edge, itr_edge, src, trig, go, fev, we, d;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cen[i] = 0; m_cend[i] = 0; m_evtd[i] = 0; m_flag[i] = 0;
                m_cnt[i] = 0; m_arr[i] = (1 << CNT_W) - 1;
                m_mms[i] = 0; m_sms[i] = 0; m_ts[i] = 0; m_msm[i] = 0; m_itrq[i] = 0;
            end
            ext_hist = '{0, 0, 0};
        end else begin
            ext_edge = (ext_hist[1] != 0) && (ext_hist[2] == 0);
            for (int i = 0; i < 2; i++) old_trgo[i] = (m_mms[i] == 1) ? m_cen[i] : 0;
            for (int i = 0; i < 2; i++) begin
                itr_edge = old_trgo[1-i] && !m_itrq[i];
                src  = (m_ts[i] == 4) ? ext_edge : (m_ts[i] == 0) ? itr_edge : 0;
                trig = (m_sms[i] == 6) && src;
                go   = m_msm[i] ? m_cend[i] : m_cen[i];
                fev  = m_msm[i] ? m_evtd[i] : trig;
                we   = wr_en && (int'(wr_unit) == i);
                d    = int'(wr_data);
                m_cend[i] = m_cen[i];
                m_evtd[i] = trig;
                m_itrq[i] = old_trgo[1-i];
                if (we && wr_addr == 1)                m_cnt[i] = d;
                else if (we && wr_addr == 3 && d[0])   m_cnt[i] = 0;
                else if (go) m_cnt[i] = (m_cnt[i] == m_arr[i]) ? 0 : m_cnt[i] + 1;
                if (we && wr_addr == 2) m_arr[i] = d;
                if (we && wr_addr == 0) begin
                    m_cen[i] = d & 1;         m_mms[i] = (d >> 1) & 7;
                    m_sms[i] = (d >> 4) & 7;  m_ts[i]  = (d >> 7) & 31;
                    m_msm[i] = (d >> 12) & 1;
                end
                if (trig) m_cen[i] = 1;
                if (fev) m_flag[i] = 1;
                else if (we && wr_addr == 4 && !d[0]) m_flag[i] = 0;
            end
            ext_hist.push_front(int'(ext_in));
            ext_hist.pop_back();
        end
    end

    // Per-cycle comparison of all outputs against the model (R5 lockstep model).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(mst_cnt) != m_cnt[0] || int'(slv_cnt) != m_cnt[1] ||
                int'(mst_flag) != m_flag[0] || int'(slv_flag) != m_flag[1] ||
                int'(mst_trgo) != ((m_mms[0] == 1) ? m_cen[0] : 0) ||
                int'(slv_trgo) != ((m_mms[1] == 1) ? m_cen[1] : 0)) begin
                errors++;
                $display("FAIL R5 model: got cnt %0d/%0d flag %0d/%0d trgo %0d/%0d exp cnt %0d/%0d flag %0d/%0d",
                         mst_cnt, slv_cnt, mst_flag, slv_flag, mst_trgo, slv_trgo,
                         m_cnt[0], m_cnt[1], m_flag[0], m_flag[1]);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input int unit, input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_unit = 1'(unit); wr_addr = 3'(addr); wr_data = DATA_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int ctl(input int msm, input int ts, input int sms,
                               input int mms, input int cen);
        return (msm << 12) | (ts << 7) | (sms << 4) | (mms << 1) | cen;
    endfunction

    // Raise the pin after holding it low, return negedges until the flag.
    task automatic fire(input bit want_slave, output int lat);
        ext_in = 1'b0;
        repeat (5) @(negedge clk);
        ext_in = 1'b1;
        lat = 0;
        while (lat < 20 && !(want_slave ? slv_flag : mst_flag)) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    int lat, v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mst_cnt", mst_cnt, 0);
        chk("R1 slv_cnt", slv_cnt, 0);
        chk("R1 flags", {mst_flag, slv_flag}, 0);
        chk("R1 trgo", {mst_trgo, slv_trgo}, 0);

        // Lockstep arming with the delay bit set.
        wr(0, 2, 100); wr(1, 2, 100);
        wr(0, 0, ctl(1, 4, 6, 1, 0));
        wr(1, 0, ctl(0, 0, 6, 0, 0));
        wr(0, 3, 1); wr(1, 3, 1);
        chk("R2 trgo idle", mst_trgo, 0);
        fire(1'b0, lat);
        chk("R3 flag latency", lat, 4);
        chk("R5 flags together", slv_flag, 1);
        chk("R4 slave armed", slv_flag, mst_flag);
        chk("R12 zeroed", mst_cnt, 0);
        chk("R2 trgo running", mst_trgo, 1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R5 equal counts", mst_cnt, slv_cnt);
        end

        // Flag clearing.
        wr(0, 4, 1);
        chk("R8 write one keeps flag", mst_flag, 1);
        wr(0, 4, 0); wr(1, 4, 0);
        chk("R8 write zero clears", mst_flag, 0);
        chk("R8 slave cleared", slv_flag, 0);

        // Wrap at the reload value.
        v = 0;
        while (v < 300 && mst_cnt != 100) begin @(negedge clk); v++; end
        @(negedge clk);
        chk("R7 master wrap", mst_cnt, 0);
        chk("R7 slave wrap", slv_cnt, 0);
        @(negedge clk);
        chk("R7 step", mst_cnt, 1);

        // Offset kept; trigger does not reset counters.
        wr(0, 0, ctl(1, 4, 6, 1, 0));
        wr(1, 0, ctl(0, 0, 6, 0, 0));
        repeat (2) @(negedge clk);
        wr(0, 1, 10); wr(1, 1, 3);
        fire(1'b0, lat);
        chk("R10 count kept", mst_cnt, 10);
        chk("R6 slave preset", slv_cnt, 3);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R6 offset", int'(mst_cnt) - int'(slv_cnt), 7);
        end
        chk("R10 resumed", mst_cnt > 10, 1);

        // Slave outside trigger mode ignores the trigger.
        wr(0, 0, ctl(1, 4, 6, 1, 0));
        wr(1, 0, ctl(0, 0, 0, 0, 0));
        wr(0, 4, 0); wr(1, 4, 0);
        repeat (2) @(negedge clk);
        v = int'(slv_cnt);
        fire(1'b0, lat);
        repeat (10) @(negedge clk);
        chk("R9 slave flag", slv_flag, 0);
        chk("R9 slave count", slv_cnt, v);

        // Delay bit clear: master leads by one.
        wr(0, 0, ctl(0, 4, 6, 1, 0));
        wr(1, 0, ctl(0, 0, 6, 0, 0));
        wr(0, 4, 0); wr(1, 4, 0);
        repeat (2) @(negedge clk);
        wr(0, 3, 1); wr(1, 3, 1);
        fire(1'b1, lat);
        chk("R11 master lead", int'(mst_cnt) - int'(slv_cnt), 1);
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            chk("R11 master lead", int'(mst_cnt) - int'(slv_cnt), 1);
        end

        // Master-mode other than 001 silences the trigger output.
        wr(0, 0, ctl(0, 4, 6, 0, 1));
        chk("R2 trgo off", mst_trgo, 0);
        v = int'(mst_cnt);
        repeat (3) @(negedge clk);
        chk("R12 still running", int'(mst_cnt) - v, 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule